// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block sits between 82 peripheral interrupt lines and a processor core. Each line gets a software-chosen priority level. A separate lowest-index encoder runs inside each level, and the highest populated level supplies the winner. The block raises a request to the core only when the winning level is above the core's current mask. Alongside the request it presents the level, the source number and the address the core should fetch from.

Normally that address is a software-set base with the 7-bit source number appended, which gives one table slot per source. Two fast slots can each claim one source and replace the table address with a full handler address of their own. While the system is in a low-power state, any enabled pending request raises a wake signal toward clock control. Out of reset, the address output holds a fixed boot fetch address.

Configuration goes through a plain register-slave port: one select strobe, a write flag, a 4-bit address and a 16-bit data word. Read data is registered. Every core-side output is registered, so a change on the request lines shows up one clock later. There is no data stream and no back-pressure. The request is a level the core samples, and it holds while the same winner stays pending.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Within one priority level, the pending source with the lowest number wins (source 0 highest, source 81 lowest).
- R2: Register r (0 to 10) holds the 2-bit priority codes of sources 8r to 8r+7, with source i at bits 2(i mod 8)+1:2(i mod 8). Code 00 disables the source, and codes 01, 10 and 11 select levels 1, 2 and 3. Bits above source 81 read as 0.
- R3: Sources 0 and 1 are fixed at level 3. Writes to their fields are ignored and the fields read back as 11.
- R4: When sources are pending at several levels, the winner comes from the highest level.
- R5: irq_req is asserted one clock after the inputs, and only when the winning level is strictly greater than core_mask. irq_level and irq_vector then give that winner's level and source number.
- R6: For a source not claimed by a fast slot, vec_addr = {vector base (register 11, bits 8:0), 7-bit source number}.
- R7: Registers 12 and 13 hold fast slot 0: source number in bits 6:0, and the handler address. Registers 14 and 15 hold slot 1 in the same layout. When the winner matches a slot, vec_addr is that slot's handler address and fast_hit sets bit 0 (slot 0) or bit 1 (slot 1). Slot 0 takes precedence when both slots name the winner. Slot sources reset to 127, which matches no source.
- R8: wake is asserted, one clock later, exactly when low_power is high and some source with a nonzero level is pending, regardless of core_mask.
- R9: After reset, irq_req is 0 and vec_addr is 16'h0200. vec_addr changes only in a cycle that raises irq_req.
- R10: A read (bus_sel high, bus_wr low) returns the addressed register on bus_rdata one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_lines | input | 82 | Peripheral request lines |
| core_mask | input | 2 | Core's current interrupt mask level |
| low_power | input | 1 | System is in wait or stop |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 2 | Level of the winning source |
| irq_vector | output | 7 | Number of the winning source |
| vec_addr | output | 16 | Fetch address for the winner, or the boot address after reset |
| fast_hit | output | 2 | Fast slot that claimed the winner |
| wake | output | 1 | Restart-clocks request |

## Verification
Each source is first raised on its own under a fixed level pattern. This separates the level decode of every field position and shows that disabled sources are ignored. Sparse multi-source patterns, combined with a mask that cycles through all four values, then set lowest-index ordering inside a level against level ordering across levels and the strict mask comparison. Directed cases cover the fixed sources, the fast-slot claim and its precedence, wake with and without enabled sources, and the boot address.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    LV_OFF = 2'd0,
    LV_1   = 2'd1,
    LV_2   = 2'd2,
    LV_3   = 2'd3
  } level_e;

  localparam int FIELDS_PER_REG = 8;
  localparam int NUM_FAST = 2;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
#(
  parameter int NUM_SRC   = 82,
  parameter int NUM_FIXED = 2,
  parameter int VEC_W     = 7,
  parameter int PC_W      = 16,
  parameter int DATA_W    = 16,
  parameter int BUS_AW    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [BUS_AW-1:0]         bus_addr,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  output logic [2*NUM_SRC-1:0]      src_lvl,
  output logic [PC_W-VEC_W-1:0]     vbase,
  output logic [NUM_FAST-1:0][VEC_W-1:0] fast_src,
  output logic [NUM_FAST-1:0][PC_W-1:0]  fast_addr
);
  localparam int PRIO_REGS = (NUM_SRC + FIELDS_PER_REG - 1) / FIELDS_PER_REG;
  localparam int PAD_W     = PRIO_REGS * DATA_W - 2 * NUM_SRC;
  localparam int VB_W      = PC_W - VEC_W;
  localparam int REG_VBASE = PRIO_REGS;
  localparam int REG_FAST0 = PRIO_REGS + 1;

  logic [PRIO_REGS-1:0][DATA_W-1:0] prio_q;
  logic [PRIO_REGS*DATA_W-1:0]      prio_view;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_field
      if (gi < NUM_FIXED) begin : g_fixed
        assign src_lvl[2*gi +: 2] = LV_3;
      end else begin : g_prog
        assign src_lvl[2*gi +: 2] =
          prio_q[gi/FIELDS_PER_REG][2*(gi%FIELDS_PER_REG) +: 2];
      end
    end
  endgenerate

  assign prio_view = {{PAD_W{1'b0}}, src_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q    <= '0;
      vbase     <= '0;
      for (int s = 0; s < NUM_FAST; s++) begin
        fast_src[s]  <= '1;
        fast_addr[s] <= '0;
      end
      bus_rdata <= '0;
    end else if (bus_sel) begin
      if (bus_wr) begin
        for (int r = 0; r < PRIO_REGS; r++)
          if (bus_addr == BUS_AW'(r)) prio_q[r] <= bus_wdata;
        if (bus_addr == BUS_AW'(REG_VBASE)) vbase <= bus_wdata[VB_W-1:0];
        for (int s = 0; s < NUM_FAST; s++) begin
          if (bus_addr == BUS_AW'(REG_FAST0 + 2*s))
            fast_src[s] <= bus_wdata[VEC_W-1:0];
          if (bus_addr == BUS_AW'(REG_FAST0 + 2*s + 1))
            fast_addr[s] <= bus_wdata[PC_W-1:0];
        end
      end else begin
        bus_rdata <= '0;
        for (int r = 0; r < PRIO_REGS; r++)
          if (bus_addr == BUS_AW'(r)) bus_rdata <= prio_view[r*DATA_W +: DATA_W];
        if (bus_addr == BUS_AW'(REG_VBASE))
          bus_rdata <= DATA_W'(vbase);
        for (int s = 0; s < NUM_FAST; s++) begin
          if (bus_addr == BUS_AW'(REG_FAST0 + 2*s))
            bus_rdata <= DATA_W'(fast_src[s]);
          if (bus_addr == BUS_AW'(REG_FAST0 + 2*s + 1))
            bus_rdata <= DATA_W'(fast_addr[s]);
        end
      end
    end
  end

  // R10: a write never disturbs the read data register
  a_r10_write_keeps_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |=> $stable(bus_rdata));
endmodule

// File: rtl/pic_lowest_enc.sv
module pic_lowest_enc #(
  parameter int N  = 82,
  parameter int IW = 7
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IW'(i);
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NUM_SRC = 82,
  parameter int VEC_W   = 7
) (
  input  logic [NUM_SRC-1:0]   irq_lines,
  input  logic [2*NUM_SRC-1:0] src_lvl,
  output logic                 win_any,
  output logic [1:0]           win_lvl,
  output logic [VEC_W-1:0]     win_vec
);
  localparam int NUM_LVL = 3;

  logic [NUM_LVL:1][NUM_SRC-1:0] lvl_req;
  logic [NUM_LVL:1]              lvl_any;
  logic [NUM_LVL:1][VEC_W-1:0]   lvl_idx;

  genvar gl, gs;
  generate
    for (gl = 1; gl <= NUM_LVL; gl++) begin : g_lvl
      for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
        assign lvl_req[gl][gs] = irq_lines[gs] && (src_lvl[2*gs +: 2] == 2'(gl));
      end
      pic_lowest_enc #(.N(NUM_SRC), .IW(VEC_W)) u_enc (
        .req (lvl_req[gl]),
        .any (lvl_any[gl]),
        .idx (lvl_idx[gl])
      );
    end
  endgenerate

  always_comb begin
    win_any = 1'b0;
    win_lvl = LV_OFF;
    win_vec = '0;
    for (int l = 1; l <= NUM_LVL; l++)
      if (lvl_any[l]) begin
        win_any = 1'b1;
        win_lvl = 2'(l);
        win_vec = lvl_idx[l];
      end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int          NUM_SRC    = 82,
  parameter int          NUM_FIXED  = 2,
  parameter int          VEC_W      = 7,
  parameter int          PC_W       = 16,
  parameter int          DATA_W     = 16,
  parameter int          BUS_AW     = 4,
  parameter logic [15:0] RESET_ADDR = 16'h0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic [1:0]         core_mask,
  input  logic               low_power,
  output logic               irq_req,
  output logic [1:0]         irq_level,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [PC_W-1:0]    vec_addr,
  output logic [NUM_FAST-1:0] fast_hit,
  output logic               wake
);
  logic [2*NUM_SRC-1:0]            src_lvl;
  logic [PC_W-VEC_W-1:0]           vbase;
  logic [NUM_FAST-1:0][VEC_W-1:0]  fast_src;
  logic [NUM_FAST-1:0][PC_W-1:0]   fast_addr;
  logic                            win_any;
  logic [1:0]                      win_lvl;
  logic [VEC_W-1:0]                win_vec;
  logic                            take;
  logic [NUM_FAST-1:0]             hit_d;
  logic [PC_W-1:0]                 addr_d;

  pic_cfg_regs #(
    .NUM_SRC(NUM_SRC), .NUM_FIXED(NUM_FIXED), .VEC_W(VEC_W),
    .PC_W(PC_W), .DATA_W(DATA_W), .BUS_AW(BUS_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_lvl(src_lvl), .vbase(vbase), .fast_src(fast_src), .fast_addr(fast_addr)
  );

  pic_arbiter #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_arb (
    .irq_lines(irq_lines), .src_lvl(src_lvl),
    .win_any(win_any), .win_lvl(win_lvl), .win_vec(win_vec)
  );

  assign take = win_any && (win_lvl > core_mask);

  always_comb begin
    hit_d  = '0;
    addr_d = {vbase, win_vec};
    for (int s = NUM_FAST - 1; s >= 0; s--)
      if (fast_src[s] == win_vec) begin
        hit_d  = '0;
        hit_d[s] = 1'b1;
        addr_d = fast_addr[s];
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req    <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
      vec_addr   <= RESET_ADDR;
      fast_hit   <= '0;
      wake       <= 1'b0;
    end else begin
      irq_req  <= take;
      wake     <= low_power && win_any;
      fast_hit <= take ? hit_d : '0;
      if (take) begin
        irq_level  <= win_lvl;
        irq_vector <= win_vec;
        vec_addr   <= addr_d;
      end
    end
  end

  a_r5_req_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_level > $past(core_mask)));
  a_r4_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_lines) |=> !irq_req);
  a_r8_wake_needs_lp: assert property (@(posedge clk) disable iff (!rst_n)
    !low_power |=> !wake);
  a_r7_fast_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_hit != '0) |-> (irq_req && $onehot0(fast_hit)));
  a_r9_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> $stable(vec_addr));
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [81:0] irq_lines = '0;
  logic [1:0]  core_mask = '0;
  logic        low_power = 1'b0;
  logic        irq_req, wake;
  logic [1:0]  irq_level, fast_hit;
  logic [6:0]  irq_vector;
  logic [15:0] vec_addr;

  int n_chk = 0, n_fail = 0;
  int cfg[82];
  int fsrc[2];
  logic [15:0] faddr[2];
  logic [8:0]  vb;
  logic [63:0] rs = 64'h9E3779B97F4A7C15;

  always #2.5 clk = ~clk;

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .core_mask(core_mask), .low_power(low_power),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
    .vec_addr(vec_addr), .fast_hit(fast_hit), .wake(wake)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 4'(a); bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = 4'(a);
    @(negedge clk); bus_sel = 0; d = bus_rdata;
  endtask

  function automatic int lvl_of(input int i);
    return (i < 2) ? 3 : cfg[i];
  endfunction

  task automatic program_prio();
    for (int r = 0; r < 11; r++) begin
      logic [15:0] w = '0;
      for (int k = 0; k < 8; k++)
        if (r*8 + k < 82) w[2*k +: 2] = 2'(cfg[r*8 + k]);
      wr(r, w);
    end
  endtask

  task automatic drive_and_check(input logic [81:0] irq, input int mask, input string tag);
    int bl = 0, bv = 0;
    bit any = 0, exp_req;
    logic [15:0] ea;
    logic [1:0] eh;
    for (int i = 81; i >= 0; i--)
      if (irq[i] && lvl_of(i) != 0 && lvl_of(i) >= bl) begin
        bl = lvl_of(i); bv = i; any = 1;
      end
    exp_req = any && (bl > mask);
    ea = {vb, 7'(bv)}; eh = 2'b00;
    if (fsrc[1] == bv) begin ea = faddr[1]; eh = 2'b10; end
    if (fsrc[0] == bv) begin ea = faddr[0]; eh = 2'b01; end
    @(negedge clk); irq_lines = irq; core_mask = 2'(mask);
    @(negedge clk);
    check(irq_req == exp_req, {tag, " R5 req"}, irq_req, exp_req);
    if (exp_req) begin
      check(irq_level == 2'(bl), {tag, " R4 level"}, irq_level, bl);
      check(irq_vector == 7'(bv), {tag, " R1 vector"}, irq_vector, bv);
      check(vec_addr == ea, {tag, " R6/R7 addr"}, vec_addr, ea);
      check(fast_hit == eh, {tag, " R7 hit"}, fast_hit, eh);
    end
  endtask

  function automatic logic [63:0] nxt();
    rs ^= rs << 13; rs ^= rs >> 7; rs ^= rs << 17;
    return rs;
  endfunction

  initial begin
    #900000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] d;
    fsrc[0] = 127; fsrc[1] = 127; faddr[0] = '0; faddr[1] = '0; vb = '0;
    for (int i = 0; i < 82; i++) cfg[i] = (i*7 + 1) % 4;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(irq_req == 0, "R9 reset req", irq_req, 0);
    check(vec_addr == 16'h0200, "R9 reset addr", vec_addr, 16'h0200);
    rd(0, d);
    check(d == 16'h000F, "R3 fixed reset read", d, 16'h000F);
    wr(0, 16'h0000); rd(0, d);
    check(d[3:0] == 4'hF, "R3 fixed write ignored", d, 16'h000F);
    program_prio();
    rd(10, d);
    check(d == {12'h0, 2'(cfg[81]), 2'(cfg[80])}, "R2 R10 readback reg10", d, {cfg[81], cfg[80]});
    rd(5, d);
    check(d[5:4] == 2'(cfg[42]), "R2 field position src42", d[5:4], cfg[42]);
    vb = 9'h1A5; wr(11, 16'(vb)); rd(11, d);
    check(d == 16'h01A5, "R10 vbase read", d, 16'h01A5);
    // R9: address still holds boot value before any request
    check(vec_addr == 16'h0200, "R9 addr held", vec_addr, 16'h0200);
    // single-source sweep, R1/R2/R5/R6
    for (int i = 0; i < 82; i++) drive_and_check(82'(1) << i, 0, "single");
    // multi-source patterns with mask cycling, R1/R4/R5
    for (int t = 0; t < 400; t++) begin
      logic [81:0] p = {nxt(), nxt()}[81:0] & {nxt(), nxt()}[81:0] & {nxt(), nxt()}[81:0];
      if (t % 5 == 0) p[1:0] = 2'b00;
      drive_and_check(p, t % 4, "multi");
    end
    // R7 fast slots: both slots name 20, slot 0 wins
    fsrc[0] = 20; faddr[0] = 16'hBEEF; fsrc[1] = 20; faddr[1] = 16'hCAFE;
    wr(12, 16'd20); wr(13, 16'hBEEF); wr(14, 16'd20); wr(15, 16'hCAFE);
    drive_and_check(82'(1) << 20, 0, "R7 slot0 precedence");
    fsrc[1] = 34; wr(14, 16'd34);
    drive_and_check(82'(1) << 34, 0, "R7 slot1");
    drive_and_check(82'(1) << 41, 0, "R7 no match");
    for (int t = 0; t < 60; t++) begin
      logic [81:0] p = {nxt(), nxt()}[81:0] & {nxt(), nxt()}[81:0];
      p[1:0] = 2'b00;
      drive_and_check(p, t % 3, "R7 mixed");
    end
    // R8 wake: source 5 disabled, source 2 level 3
    @(negedge clk); low_power = 1; core_mask = 2'd3; irq_lines = 82'(1) << 5;
    @(negedge clk);
    check(wake == 0, "R8 disabled no wake", wake, 0);
    check(irq_req == 0, "R2 disabled no req", irq_req, 0);
    irq_lines = 82'(1) << 2;
    @(negedge clk);
    check(wake == 1, "R8 wake masked", wake, 1);
    check(irq_req == 0, "R5 mask 3 blocks", irq_req, 0);
    low_power = 0;
    @(negedge clk);
    check(wake == 0, "R8 no wake when active", wake, 0);
    irq_lines = '0;
    @(negedge clk);
    check(irq_req == 0, "R5 idle", irq_req, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule